// File: doc/BRIEF.md
# Masked Control/Status Register File

This block holds the machine-level and supervisor-level control/status registers of a processor hart. It has one write port and one combinational read port, each addressed by the 12-bit register number. Every write passes through a per-register writable mask, so fields that are read-only or not implemented keep their value. Some values are never stored. The status dirty summary is computed from the float and extension state fields. The supervisor status, interrupt-pending and interrupt-enable registers are masked views of the machine copies.

The block also holds the retired-instruction counter. The counter advances on a one-cycle retire pulse and can be written as two 32-bit halves on 32-bit builds. Reads of the user-level counter alias are gated by the current privilege level and the two counter-enable registers. The float flags and rounding mode are reachable only while the F extension bit of the ISA register is set. A read or write to an address that does not exist is flagged as illegal. A write to a read-only address is flagged the same way. Illegal writes change nothing.

Top module: `csr_regfile`

## Requirements
- R1: After reset, the ISA register holds the base-width code in its top two bits (1 for XLEN=32, 2 for XLEN=64) and extension bits A(0), C(2), D(3), F(5), I(8), M(12), S(18), U(20). The machine trap vector equals RESET_MTVEC. Vendor, architecture and implementation IDs (0xF11–0xF13) read 0, the hart ID (0xF14) reads HART_ID, and all other registers read 0.
- R2: A write to the machine status register (0x300) changes only bits 1, 3, 5, 7, 8, 11–14 and 17–22. Bits 15–16 (extension state) are writable only when HAS_XEXT=1.
- R3: The top bit of the machine status register reads 1 exactly when bits 14:13 or bits 16:15 are both ones. The same holds for the supervisor status view.
- R4: The supervisor status register (0x100) reads the machine status ANDed with bits 1, 5, 8, 13–16 and 18, plus the derived top bit. A write to it changes only those bits.
- R5: Interrupt bits are SSIP=1, MSIP=3, STIP=5, MTIP=7, SEIP=9 and bit 12 for the coprocessor. A write to the pending register (0x344) changes only SSIP and STIP. The delegation register (0x303) keeps only bits 1, 5, 9 and 12. The enable register (0x304) keeps those bits plus 3 and 7.
- R6: The supervisor pending (0x144) and enable (0x104) registers read as the machine copies ANDed with the delegation register. A supervisor enable write changes only delegated bits. A supervisor pending write changes only SSIP, and only while SSIP is delegated.
- R7: Writes to the supervisor (0x105) and machine (0x305) trap vectors store the value with bits 1:0 cleared.
- R8: In the ISA register (0x301) only bits A, C, D, F and M are writable. A write with F=0 also clears D.
- R9: The retire counter increments by one per cycle with retire_i high. A write in the same cycle takes precedence over the increment. With XLEN=32, a write to the low half (0xB02) keeps bits 63:32, and a write to the high half (0xB82) keeps bits 31:0.
- R10: Reads of the user counter alias (0xC02, and 0xC82 for XLEN=32) use bit index rd_addr[4:0]. Below machine mode (priv_i<3) the read needs that bit set in the machine counter-enable register (0x306). In user mode (priv_i=0) it also needs that bit in the supervisor counter-enable register (0x106). Otherwise the read is illegal.
- R11: The flags register (0x001) holds 5 bits and the rounding register (0x002) holds 3 bits. The combined register (0x003) reads flags in bits 4:0 and rounding mode in bits 7:5. All three are illegal to read or write while ISA bit F is 0.
- R12: A read of an unimplemented address raises rd_illegal_o and returns 0. A write to an unimplemented or read-only address (0xC02, 0xC82, 0xF11–0xF14) raises wr_illegal_o and changes no register.
- R13: Exception delegation (0x302) keeps bits 0–9, 12, 13 and 15. The scratch, exception PC, cause and bad-address registers of both levels store all XLEN bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write register number |
| wr_data_i | input | XLEN | Write data |
| retire_i | input | 1 | One instruction retired this cycle |
| rd_addr_i | input | 12 | Read register number |
| rd_data_o | output | XLEN | Read data (0 when illegal) |
| rd_illegal_o | output | 1 | Read access is illegal |
| wr_illegal_o | output | 1 | Write access is illegal and is dropped |

## Verification
The bench builds the block with XLEN=32, HAS_XEXT=1, HART_ID=5 and RESET_MTVEC=0x100. The 32-bit width makes the split counter halves reachable, including a carry out of the low half into the high half. The extension flag makes the extension-state bits writable, so the dirty summary can be driven from either field. The nonzero hart ID and reset vector separate the reset values from a cleared register.

// File: rtl/csr_rf_pkg.sv
package csr_rf_pkg;

    typedef enum logic [5:0] {
        SEL_NONE,
        SEL_FFLAGS, SEL_FRM, SEL_FCSR,
        SEL_SSTAT, SEL_SIE, SEL_STVEC, SEL_SCEN, SEL_SSCR, SEL_SEPC, SEL_SCAUSE, SEL_SBAD, SEL_SIP,
        SEL_MSTAT, SEL_MISA, SEL_MEDELEG, SEL_MIDELEG, SEL_MIE, SEL_MTVEC, SEL_MCEN,
        SEL_MSCR, SEL_MEPC, SEL_MCAUSE, SEL_MBAD, SEL_MIP,
        SEL_MRET_LO, SEL_MRET_HI, SEL_URET_LO, SEL_URET_HI,
        SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART
    } csr_sel_e;

    // status field positions
    localparam int unsigned FS_LO = 13;
    localparam int unsigned XS_LO = 15;

    localparam logic [31:0] STAT_WMASK_BASE = 32'h007E_79AA;
    localparam logic [31:0] STAT_XS_MASK    = 32'h0001_8000;
    localparam logic [31:0] SSTAT_VIEW      = 32'h0005_E122;

    // interrupt bit groups
    localparam logic [31:0] IRQ_SW_WR     = 32'h0000_0022;
    localparam logic [31:0] IRQ_DELEGABLE = 32'h0000_1222;
    localparam logic [31:0] IRQ_ALL       = 32'h0000_12AA;
    localparam logic [31:0] IRQ_SSIP      = 32'h0000_0002;

    localparam logic [31:0] EXC_DELEGABLE = 32'h0000_B3FF;

    // ISA register letters: A0 C2 D3 F5 I8 M12 S18 U20
    localparam int unsigned ISA_D = 3;
    localparam int unsigned ISA_F = 5;
    localparam logic [31:0] ISA_WMASK   = 32'h0000_102D;
    localparam logic [31:0] ISA_RST_EXT = 32'h0014_112D;

endpackage

// File: rtl/csr_sel_decode.sv
module csr_sel_decode
    import csr_rf_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [11:0] addr_i,
    output csr_sel_e    sel_o,
    output logic        hit_o
);
    localparam bit HAS_HALVES = (XLEN == 32);

    always_comb begin
        sel_o = SEL_NONE;
        case (addr_i)
            12'h001: sel_o = SEL_FFLAGS;
            12'h002: sel_o = SEL_FRM;
            12'h003: sel_o = SEL_FCSR;
            12'h100: sel_o = SEL_SSTAT;
            12'h104: sel_o = SEL_SIE;
            12'h105: sel_o = SEL_STVEC;
            12'h106: sel_o = SEL_SCEN;
            12'h140: sel_o = SEL_SSCR;
            12'h141: sel_o = SEL_SEPC;
            12'h142: sel_o = SEL_SCAUSE;
            12'h143: sel_o = SEL_SBAD;
            12'h144: sel_o = SEL_SIP;
            12'h300: sel_o = SEL_MSTAT;
            12'h301: sel_o = SEL_MISA;
            12'h302: sel_o = SEL_MEDELEG;
            12'h303: sel_o = SEL_MIDELEG;
            12'h304: sel_o = SEL_MIE;
            12'h305: sel_o = SEL_MTVEC;
            12'h306: sel_o = SEL_MCEN;
            12'h340: sel_o = SEL_MSCR;
            12'h341: sel_o = SEL_MEPC;
            12'h342: sel_o = SEL_MCAUSE;
            12'h343: sel_o = SEL_MBAD;
            12'h344: sel_o = SEL_MIP;
            12'hB02: sel_o = SEL_MRET_LO;
            12'hB82: sel_o = HAS_HALVES ? SEL_MRET_HI : SEL_NONE;
            12'hC02: sel_o = SEL_URET_LO;
            12'hC82: sel_o = HAS_HALVES ? SEL_URET_HI : SEL_NONE;
            12'hF11: sel_o = SEL_VENDOR;
            12'hF12: sel_o = SEL_ARCH;
            12'hF13: sel_o = SEL_IMPL;
            12'hF14: sel_o = SEL_HART;
            default: sel_o = SEL_NONE;
        endcase
        hit_o = (sel_o != SEL_NONE);
    end
endmodule

// File: rtl/csr_retire_ctr.sv
module csr_retire_ctr #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic            wr_lo_i,
    input  logic            wr_hi_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [63:0]     count_o
);
    logic [63:0] cnt_d, cnt_q;
    logic [63:0] wr_val;

    generate
        if (XLEN == 32) begin : g_split
            always_comb begin
                if (wr_hi_i) wr_val = {wr_data_i[31:0], cnt_q[31:0]};
                else         wr_val = {cnt_q[63:32], wr_data_i[31:0]};
            end
            // R9: a high-half write leaves the low half alone
            a_r9_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hi_i |=> cnt_q[31:0] == $past(cnt_q[31:0]));
        end else begin : g_full
            always_comb wr_val = 64'(wr_data_i);
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo_i || wr_hi_i) cnt_d = wr_val;
        else if (retire_i)      cnt_d = cnt_q + 64'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    a_r9_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == $past(cnt_q) + 64'd1);
endmodule

// File: rtl/csr_read_port.sv
module csr_read_port
    import csr_rf_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned HART_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  csr_sel_e        sel_i,
    input  logic            hit_i,
    input  logic [4:0]      ctr_idx_i,
    input  logic [1:0]      priv_i,
    input  logic [XLEN-1:0] mstat_i,
    input  logic [XLEN-1:0] mip_i,
    input  logic [XLEN-1:0] mie_i,
    input  logic [XLEN-1:0] mideleg_i,
    input  logic [XLEN-1:0] medeleg_i,
    input  logic [XLEN-1:0] stvec_i,
    input  logic [XLEN-1:0] mtvec_i,
    input  logic [XLEN-1:0] sscr_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic [XLEN-1:0] scause_i,
    input  logic [XLEN-1:0] sbad_i,
    input  logic [XLEN-1:0] mscr_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic [XLEN-1:0] mcause_i,
    input  logic [XLEN-1:0] mbad_i,
    input  logic [XLEN-1:0] misa_i,
    input  logic [31:0]     mcen_i,
    input  logic [31:0]     scen_i,
    input  logic [4:0]      fflags_i,
    input  logic [2:0]      frm_i,
    input  logic [63:0]     count_i,
    output logic [XLEN-1:0] data_o,
    output logic            illegal_o
);
    localparam logic [XLEN-1:0] SD_BIT = XLEN'(1) << (XLEN - 1);

    logic            dirty;
    logic [XLEN-1:0] sd;
    logic [31:0]     ctr_en;
    logic            ctr_ok;
    logic            is_float;
    logic            is_uctr;
    logic [XLEN-1:0] raw;

    always_comb begin
        dirty = (mstat_i[FS_LO +: 2] == 2'b11) || (mstat_i[XS_LO +: 2] == 2'b11);
        sd    = dirty ? SD_BIT : '0;

        ctr_en = '1;
        if (priv_i < 2'd3) ctr_en = ctr_en & mcen_i;
        if (priv_i < 2'd1) ctr_en = ctr_en & scen_i;
        ctr_ok = ctr_en[ctr_idx_i];

        is_float = (sel_i == SEL_FFLAGS) || (sel_i == SEL_FRM) || (sel_i == SEL_FCSR);
        is_uctr  = (sel_i == SEL_URET_LO) || (sel_i == SEL_URET_HI);

        case (sel_i)
            SEL_FFLAGS:  raw = XLEN'(fflags_i);
            SEL_FRM:     raw = XLEN'(frm_i);
            SEL_FCSR:    raw = XLEN'({frm_i, fflags_i});
            SEL_SSTAT:   raw = (mstat_i & XLEN'(SSTAT_VIEW)) | sd;
            SEL_SIE:     raw = mie_i & mideleg_i;
            SEL_SIP:     raw = mip_i & mideleg_i;
            SEL_STVEC:   raw = stvec_i;
            SEL_SCEN:    raw = XLEN'(scen_i);
            SEL_SSCR:    raw = sscr_i;
            SEL_SEPC:    raw = sepc_i;
            SEL_SCAUSE:  raw = scause_i;
            SEL_SBAD:    raw = sbad_i;
            SEL_MSTAT:   raw = mstat_i | sd;
            SEL_MISA:    raw = misa_i;
            SEL_MEDELEG: raw = medeleg_i;
            SEL_MIDELEG: raw = mideleg_i;
            SEL_MIE:     raw = mie_i;
            SEL_MTVEC:   raw = mtvec_i;
            SEL_MCEN:    raw = XLEN'(mcen_i);
            SEL_MSCR:    raw = mscr_i;
            SEL_MEPC:    raw = mepc_i;
            SEL_MCAUSE:  raw = mcause_i;
            SEL_MBAD:    raw = mbad_i;
            SEL_MIP:     raw = mip_i;
            SEL_MRET_LO, SEL_URET_LO: raw = count_i[XLEN-1:0];
            SEL_MRET_HI, SEL_URET_HI: raw = XLEN'(count_i[63:32]);
            SEL_HART:    raw = XLEN'(HART_ID);
            default:     raw = '0;
        endcase

        illegal_o = !hit_i || (is_float && !misa_i[ISA_F]) || (is_uctr && !ctr_ok);
        data_o    = illegal_o ? '0 : raw;
    end

    a_r3_sd_tracks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_MSTAT) |-> data_o[XLEN-1] ==
            ((mstat_i[FS_LO +: 2] == 2'b11) || (mstat_i[XS_LO +: 2] == 2'b11)));
    a_r6_sip_within_deleg: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_SIP || sel_i == SEL_SIE) |-> (data_o & ~mideleg_i) == '0);
    a_r12_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> data_o == '0);
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_rf_pkg::*;
#(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned HART_ID     = 0,
    parameter bit          HAS_XEXT    = 1'b1,
    parameter logic [31:0] RESET_MTVEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      priv_i,
    input  logic            wr_en_i,
    input  logic [11:0]     wr_addr_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic            retire_i,
    input  logic [11:0]     rd_addr_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            rd_illegal_o,
    output logic            wr_illegal_o
);
    localparam logic [1:0]      MXL_CODE   = (XLEN == 64) ? 2'd2 : 2'd1;
    localparam logic [XLEN-1:0] MISA_RST   = XLEN'(ISA_RST_EXT) | (XLEN'(MXL_CODE) << (XLEN - 2));
    localparam logic [XLEN-1:0] STAT_WMASK = XLEN'(STAT_WMASK_BASE) | (HAS_XEXT ? XLEN'(STAT_XS_MASK) : '0);
    localparam logic [XLEN-1:0] VEC_MASK   = ~XLEN'(3);

    typedef struct packed {
        logic [XLEN-1:0] mstat;
        logic [XLEN-1:0] mip;
        logic [XLEN-1:0] mie;
        logic [XLEN-1:0] mideleg;
        logic [XLEN-1:0] medeleg;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] mtvec;
        logic [XLEN-1:0] sscr;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sbad;
        logic [XLEN-1:0] mscr;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mbad;
        logic [XLEN-1:0] misa;
        logic [31:0]     mcen;
        logic [31:0]     scen;
        logic [4:0]      fflags;
        logic [2:0]      frm;
    } regs_t;

    regs_t r_d, r_q;

    csr_sel_e    wr_sel, rd_sel;
    logic        wr_hit, rd_hit;
    logic        wr_ok;
    logic        wr_ro, wr_float;
    logic [63:0] count;

    function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                              input logic [XLEN-1:0] new_v,
                                              input logic [XLEN-1:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    csr_sel_decode #(.XLEN(XLEN)) u_wr_dec (.addr_i(wr_addr_i), .sel_o(wr_sel), .hit_o(wr_hit));
    csr_sel_decode #(.XLEN(XLEN)) u_rd_dec (.addr_i(rd_addr_i), .sel_o(rd_sel), .hit_o(rd_hit));

    always_comb begin
        wr_ro = (wr_sel == SEL_URET_LO) || (wr_sel == SEL_URET_HI) || (wr_sel == SEL_VENDOR)
             || (wr_sel == SEL_ARCH) || (wr_sel == SEL_IMPL) || (wr_sel == SEL_HART);
        wr_float = (wr_sel == SEL_FFLAGS) || (wr_sel == SEL_FRM) || (wr_sel == SEL_FCSR);
        wr_illegal_o = !wr_hit || wr_ro || (wr_float && !r_q.misa[ISA_F]);
        wr_ok = wr_en_i && !wr_illegal_o;
    end

    always_comb begin
        logic [XLEN-1:0] tmp;
        r_d = r_q;
        tmp = wr_data_i;
        if (wr_ok) begin
            case (wr_sel)
                SEL_MSTAT: r_d.mstat = merge(r_q.mstat, wr_data_i, STAT_WMASK);
                SEL_SSTAT: begin
                    tmp = merge(r_q.mstat, wr_data_i, XLEN'(SSTAT_VIEW));
                    r_d.mstat = merge(r_q.mstat, tmp, STAT_WMASK);
                end
                SEL_MIP:     r_d.mip = merge(r_q.mip, wr_data_i, XLEN'(IRQ_SW_WR));
                SEL_SIP:     r_d.mip = merge(r_q.mip, wr_data_i, XLEN'(IRQ_SSIP) & r_q.mideleg);
                SEL_MIE:     r_d.mie = merge(r_q.mie, wr_data_i, XLEN'(IRQ_ALL));
                SEL_SIE: begin
                    tmp = merge(r_q.mie, wr_data_i, r_q.mideleg);
                    r_d.mie = merge(r_q.mie, tmp, XLEN'(IRQ_ALL));
                end
                SEL_MIDELEG: r_d.mideleg = merge(r_q.mideleg, wr_data_i, XLEN'(IRQ_DELEGABLE));
                SEL_MEDELEG: r_d.medeleg = merge(r_q.medeleg, wr_data_i, XLEN'(EXC_DELEGABLE));
                SEL_STVEC:   r_d.stvec  = wr_data_i & VEC_MASK;
                SEL_MTVEC:   r_d.mtvec  = wr_data_i & VEC_MASK;
                SEL_SSCR:    r_d.sscr   = wr_data_i;
                SEL_SEPC:    r_d.sepc   = wr_data_i;
                SEL_SCAUSE:  r_d.scause = wr_data_i;
                SEL_SBAD:    r_d.sbad   = wr_data_i;
                SEL_MSCR:    r_d.mscr   = wr_data_i;
                SEL_MEPC:    r_d.mepc   = wr_data_i;
                SEL_MCAUSE:  r_d.mcause = wr_data_i;
                SEL_MBAD:    r_d.mbad   = wr_data_i;
                SEL_MISA: begin
                    if (!wr_data_i[ISA_F]) tmp[ISA_D] = 1'b0;
                    r_d.misa = merge(r_q.misa, tmp, XLEN'(ISA_WMASK));
                end
                SEL_MCEN:    r_d.mcen   = wr_data_i[31:0];
                SEL_SCEN:    r_d.scen   = wr_data_i[31:0];
                SEL_FFLAGS:  r_d.fflags = wr_data_i[4:0];
                SEL_FRM:     r_d.frm    = wr_data_i[2:0];
                SEL_FCSR: begin
                    r_d.fflags = wr_data_i[4:0];
                    r_d.frm    = wr_data_i[7:5];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.mtvec <= XLEN'(RESET_MTVEC);
            r_q.misa  <= MISA_RST;
        end else begin
            r_q <= r_d;
        end
    end

    csr_retire_ctr #(.XLEN(XLEN)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .wr_lo_i   (wr_ok && (wr_sel == SEL_MRET_LO)),
        .wr_hi_i   (wr_ok && (wr_sel == SEL_MRET_HI)),
        .wr_data_i (wr_data_i),
        .count_o   (count)
    );

    csr_read_port #(.XLEN(XLEN), .HART_ID(HART_ID)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (rd_sel),
        .hit_i     (rd_hit),
        .ctr_idx_i (rd_addr_i[4:0]),
        .priv_i    (priv_i),
        .mstat_i   (r_q.mstat),
        .mip_i     (r_q.mip),
        .mie_i     (r_q.mie),
        .mideleg_i (r_q.mideleg),
        .medeleg_i (r_q.medeleg),
        .stvec_i   (r_q.stvec),
        .mtvec_i   (r_q.mtvec),
        .sscr_i    (r_q.sscr),
        .sepc_i    (r_q.sepc),
        .scause_i  (r_q.scause),
        .sbad_i    (r_q.sbad),
        .mscr_i    (r_q.mscr),
        .mepc_i    (r_q.mepc),
        .mcause_i  (r_q.mcause),
        .mbad_i    (r_q.mbad),
        .misa_i    (r_q.misa),
        .mcen_i    (r_q.mcen),
        .scen_i    (r_q.scen),
        .fflags_i  (r_q.fflags),
        .frm_i     (r_q.frm),
        .count_i   (count),
        .data_o    (rd_data_o),
        .illegal_o (rd_illegal_o)
    );

    a_r7_mtvec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_sel == SEL_MTVEC) |=> r_q.mtvec == ($past(wr_data_i) & VEC_MASK));
    a_r5_mip_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_sel == SEL_MIP) |=> r_q.mip == ($past(wr_data_i) & XLEN'(IRQ_SW_WR)));
    a_r8_no_d_without_f: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.misa[ISA_F] |-> !r_q.misa[ISA_D]);
    a_r12_dropped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_illegal_o) |=> $stable(r_q.mstat) && $stable(r_q.misa)
                                      && $stable(r_q.mip) && $stable(r_q.fflags));
endmodule

// File: tb/sim_csr_regfile.sv
`timescale 1ns/1ps
module sim_csr_regfile;
    localparam int XL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    priv = 2'd3;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [XL-1:0] wr_data = '0;
    logic          retire = 1'b0;
    logic [11:0]   rd_addr = '0;
    logic [XL-1:0] rd_data;
    logic          rd_ill, wr_ill;

    always #2 clk = ~clk;

    csr_regfile #(.XLEN(XL), .HART_ID(5), .HAS_XEXT(1'b1), .RESET_MTVEC(32'h100)) u0 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .retire_i(retire), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .rd_illegal_o(rd_ill), .wr_illegal_o(wr_ill));

    typedef struct {
        bit          is_wr;
        logic [31:0] exp;
        bit          ill;
        string       tag;
    } item_t;

    item_t q[$];
    bit    go = 1'b0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    // monitor: compare at the falling edge, half a cycle away from state updates
    always @(negedge clk) begin
        if (go && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (it.is_wr) begin
                if (wr_ill !== it.ill) begin
                    bad++;
                    $display("FAIL %s: wr_illegal=%0b expected %0b", it.tag, wr_ill, it.ill);
                end
            end else if (rd_ill !== it.ill || (!it.ill && rd_data !== it.exp)) begin
                bad++;
                $display("FAIL %s: data=%h ill=%0b expected data=%h ill=%0b",
                         it.tag, rd_data, rd_ill, it.exp, it.ill);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [1:0] p, input logic [31:0] exp,
                      input bit ill, input string tag);
        @(posedge clk); #1;
        rd_addr = a; priv = p;
        q.push_back('{1'b0, exp, ill, tag});
        go = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit ill,
                      input bit ret, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d; retire = ret;
        q.push_back('{1'b1, 32'h0, ill, tag});
        go = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; retire = 1'b0; go = 1'b0;
    endtask

    task automatic retire_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            go = 1'b0; retire = 1'b1;
        end
        @(posedge clk); #1;
        retire = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(12'h301, 3, 32'h4014112D, 0, "R1 isa reset");
        rd(12'h305, 3, 32'h00000100, 0, "R1 mtvec reset");
        rd(12'h300, 3, 32'h0, 0, "R1 mstatus reset");
        rd(12'hF14, 3, 32'd5, 0, "R1 hart id");
        rd(12'hF11, 3, 32'h0, 0, "R1 vendor id");
        rd(12'hF13, 3, 32'h0, 0, "R1 impl id");

        // R2 R3 R4 status masking and dirty summary
        wr(12'h300, 32'hFFFFFFFF, 0, 0, "R2 write");
        rd(12'h300, 3, 32'h807FF9AA, 0, "R2 mstatus mask");
        rd(12'h100, 3, 32'h8005E122, 0, "R4 sstatus view");
        wr(12'h100, 32'h0, 0, 0, "R4 write");
        rd(12'h300, 3, 32'h007A1888, 0, "R4 sstatus write touches view only");
        wr(12'h300, 32'h00018000, 0, 0, "R3 write");
        rd(12'h300, 3, 32'h80018000, 0, "R3 dirty from XS");
        wr(12'h300, 32'h00002000, 0, 0, "R3 write");
        rd(12'h300, 3, 32'h00002000, 0, "R3 FS partial not dirty");

        // R5 R6 interrupts
        wr(12'h344, 32'h0000FFFF, 0, 0, "R5 write");
        rd(12'h344, 3, 32'h22, 0, "R5 mip sw bits");
        wr(12'h303, 32'hFFFFFFFF, 0, 0, "R5 write");
        rd(12'h303, 3, 32'h1222, 0, "R5 mideleg mask");
        wr(12'h304, 32'hFFFFFFFF, 0, 0, "R5 write");
        rd(12'h304, 3, 32'h12AA, 0, "R5 mie mask");
        rd(12'h144, 3, 32'h22, 0, "R6 sip view");
        rd(12'h104, 3, 32'h1222, 0, "R6 sie view");
        wr(12'h303, 32'h20, 0, 0, "R6 write");
        wr(12'h144, 32'h0, 0, 0, "R6 write");
        rd(12'h344, 3, 32'h22, 0, "R6 sip write ignored when SSIP undelegated");
        rd(12'h144, 3, 32'h20, 0, "R6 sip view narrow deleg");
        wr(12'h303, 32'h2, 0, 0, "R6 write");
        wr(12'h144, 32'h0, 0, 0, "R6 write");
        rd(12'h344, 3, 32'h20, 0, "R6 sip clears delegated SSIP");
        wr(12'h104, 32'h0, 0, 0, "R6 write");
        rd(12'h304, 3, 32'h12A8, 0, "R6 sie write delegated only");

        // R7 vectors
        wr(12'h305, 32'h12345677, 0, 0, "R7 write");
        rd(12'h305, 3, 32'h12345674, 0, "R7 mtvec align");
        wr(12'h105, 32'hFFFFFFFF, 0, 0, "R7 write");
        rd(12'h105, 3, 32'hFFFFFFFC, 0, "R7 stvec align");

        // R8 R11 isa and float
        wr(12'h301, 32'h0, 0, 0, "R8 write");
        rd(12'h301, 3, 32'h40140100, 0, "R8 isa clear MAFDC");
        rd(12'h003, 3, 32'h0, 1, "R11 fcsr read without F");
        wr(12'h003, 32'hFF, 1, 0, "R11 fcsr write without F");
        wr(12'h301, 32'h0000100C, 0, 0, "R8 write");
        rd(12'h301, 3, 32'h40141104, 0, "R8 F=0 forces D=0");
        wr(12'h301, 32'hFFFFFFFF, 0, 0, "R8 write");
        rd(12'h301, 3, 32'h4014112D, 0, "R8 isa restore");
        wr(12'h003, 32'h1FF, 0, 0, "R11 write");
        rd(12'h003, 3, 32'hFF, 0, "R11 fcsr pack");
        rd(12'h001, 3, 32'h1F, 0, "R11 flags");
        rd(12'h002, 3, 32'h7, 0, "R11 rounding");
        wr(12'h001, 32'h3, 0, 0, "R11 write");
        rd(12'h003, 3, 32'hE3, 0, "R11 flags update");
        wr(12'h002, 32'h2, 0, 0, "R11 write");
        rd(12'h003, 3, 32'h43, 0, "R11 rounding update");

        // R9 counter
        wr(12'hB02, 32'hFFFFFFFE, 0, 0, "R9 write");
        wr(12'hB82, 32'h7, 0, 0, "R9 write");
        rd(12'hB02, 3, 32'hFFFFFFFE, 0, "R9 low half");
        rd(12'hB82, 3, 32'h7, 0, "R9 high half");
        retire_n(3);
        rd(12'hB02, 3, 32'h1, 0, "R9 carry low");
        rd(12'hB82, 3, 32'h8, 0, "R9 carry high");
        wr(12'hB82, 32'h20, 0, 0, "R9 write");
        rd(12'hB02, 3, 32'h1, 0, "R9 high write keeps low");
        wr(12'hB02, 32'h50, 0, 1, "R9 write with retire");
        rd(12'hB02, 3, 32'h50, 0, "R9 write beats retire");
        rd(12'hB82, 3, 32'h20, 0, "R9 low write keeps high");

        // R10 gating
        rd(12'hC02, 1, 32'h0, 1, "R10 S without mcen");
        rd(12'hC02, 3, 32'h50, 0, "R10 M always");
        wr(12'h306, 32'h4, 0, 0, "R10 write");
        rd(12'hC02, 1, 32'h50, 0, "R10 S with mcen");
        rd(12'hC02, 0, 32'h0, 1, "R10 U without scen");
        wr(12'h106, 32'h4, 0, 0, "R10 write");
        rd(12'hC02, 0, 32'h50, 0, "R10 U with both");
        rd(12'hC82, 0, 32'h20, 0, "R10 U high half");

        // R12 illegal accesses
        rd(12'h7C0, 3, 32'h0, 1, "R12 unknown read");
        rd(12'hC00, 3, 32'h0, 1, "R12 absent counter read");
        wr(12'h7C0, 32'h1, 1, 0, "R12 unknown write");
        wr(12'hF14, 32'h99, 1, 0, "R12 hart id write");
        rd(12'hF14, 3, 32'd5, 0, "R12 hart id unchanged");
        wr(12'hC02, 32'h0, 1, 0, "R12 user counter write");
        rd(12'hB02, 3, 32'h50, 0, "R12 counter unchanged");

        // R13 plain and delegation
        wr(12'h302, 32'hFFFFFFFF, 0, 0, "R13 write");
        rd(12'h302, 3, 32'hB3FF, 0, "R13 medeleg mask");
        wr(12'h340, 32'hDEADBEEF, 0, 0, "R13 write");
        rd(12'h340, 3, 32'hDEADBEEF, 0, "R13 mscratch");
        wr(12'h143, 32'hA5A5A5A5, 0, 0, "R13 write");
        rd(12'h143, 3, 32'hA5A5A5A5, 0, "R13 sbad");

        @(posedge clk); #1 go = 1'b0;
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule